// File: doc/BRIEF.md
# Character-Oriented Synchronous Receiver with Sync Hunt

This block sits behind the serial input of a synchronous character-oriented link. It gets one data bit per strobe. After reset, or after a hunt command, it searches the bit stream for a programmed sync pattern. The pattern is either one byte long (single-sync) or two bytes long (double-sync). In a third mode an external pin sets the character boundary, and the bit stream is not searched at all.

Once synchronised, the block groups the bits that follow into characters of 5, 6, 7 or 8 bits and presents each character with a one-cycle valid pulse. It can also run a 16-bit CRC over the data bits that follow the sync. The CRC polynomial is selectable, and a status output reports a zero remainder. A frame that carries its own check bits therefore leaves the flag set when it arrives intact.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `sync_found`, `char_valid` and `crc_zero` are all low and the block is hunting.
- R2: In single-sync mode (`mode` = 0 or 3), the hunt ends when the last 8 received bits equal `sync_lo`. Bits arrive least significant first, so the first bit of the pattern is `sync_lo[0]`. `sync_found` goes high in the cycle after the strobe that carries the final pattern bit, and never before that strobe.
- R3: In double-sync mode (`mode` = 1), the hunt ends only when the last 16 bits equal `{sync_hi, sync_lo}`, sent `sync_lo` first. A match of `sync_lo` alone does not end the hunt.
- R4: The comparison slides by one bit on every strobe, so a pattern is found at any bit offset after any number of preceding bits.
- R5: In external mode (`mode` = 2), the serial pattern is ignored. `ext_sync` high at a clock edge while hunting sets `sync_found` in the next cycle.
- R6: After sync, characters are `len_code`+5 bits long. `char_data` is right-justified, with the first received bit in bit 0 and the unused upper bits zero. `char_valid` pulses for one cycle, in the cycle after the strobe that carries the last bit of the character.
- R7: A `hunt_cmd` pulse clears `sync_found`, stops character output and restarts the hunt with an empty window. Bits received before the pulse never count toward a match.
- R8: The CRC is preset at sync detection: to 0x0000 for CRC-16 (`crc_sel` = 0, polynomial 0x8005) and to 0xFFFF for CRC-CCITT (`crc_sel` = 1, polynomial 0x1021). It advances once per data bit in arrival order. `crc_zero` is high while synchronised and the remainder is zero, for example after a message followed by its 16 check bits sent most significant bit first.
- R9: While `crc_en` is low, data bits do not change the accumulator and `crc_zero` holds its value.
- R10: Sync pattern bits are neither emitted as characters nor included in the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Strobe: `rx_bit` holds a new serial bit |
| rx_bit | input | 1 | Serial data bit |
| mode | input | 2 | 0/3 single-sync, 1 double-sync, 2 external |
| sync_lo | input | 8 | Sync pattern bits 7..0 |
| sync_hi | input | 8 | Sync pattern bits 15..8 (double-sync only) |
| len_code | input | 2 | Character length minus 5 |
| crc_sel | input | 1 | 0 CRC-16, 1 CRC-CCITT |
| crc_en | input | 1 | Include data bits in the CRC |
| hunt_cmd | input | 1 | Restart the hunt |
| ext_sync | input | 1 | External character-alignment mark |
| char_valid | output | 1 | One-cycle pulse with a new character |
| char_data | output | 8 | Received character, right-justified |
| sync_found | output | 1 | Synchronised (hunt finished) |
| crc_zero | output | 1 | CRC remainder is zero while synchronised |

## Verification
The bench places the pattern behind junk bits, so a design that compares only on byte boundaries would never lock. It checks that the flag stays low one bit before the pattern completes, which catches a design that matches on a partial window. In double-sync mode it sends the low byte alone, which catches a design that compares only 8 bits. It splits a pattern across a hunt command, which catches a design that keeps stale window contents. It also streams the pattern while in external mode, which catches a design that still searches the bit stream there.

The bench checks each character length, where an off-by-one framing counter or a wrong justification shows up as a wrong character value. It appends check bits under both polynomials and verifies that the remainder returns to zero. It also checks that a corrupted bit, or a byte received with the CRC disabled, gives the flag that the bench's own CRC model predicts.

// File: rtl/sync_rx_pkg.sv
// Package: shared mode encoding and CRC constants for the sync-hunt receiver.
// Assumes a 16-bit CRC and a two-bit mode field.
package sync_rx_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_DOUBLE = 2'd1,
        MODE_EXT    = 2'd2,
        MODE_SINGLE_ALT = 2'd3
    } hunt_mode_e;

    localparam int          CRC_W       = 16;
    localparam logic [15:0] POLY_CRC16  = 16'h8005;
    localparam logic [15:0] POLY_CCITT  = 16'h1021;
    localparam logic [15:0] SEED_CRC16  = 16'h0000;
    localparam logic [15:0] SEED_CCITT  = 16'hFFFF;
endpackage

// File: rtl/sync_window.sv
// Sliding pattern window: shifts one bit per strobe (new bit enters at the
// top, so the first received bit ends at bit 0) and reports a match of
// either the upper half against the low pattern half, or the whole window
// against the whole pattern. Assumes W is even. A fill counter keeps a
// match from being reported before enough bits have arrived since a clear.
module sync_window #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         din,
    input  logic         wide,
    input  logic [W-1:0] pattern,
    output logic         match
);
    localparam int HALF = W / 2;
    localparam int FW   = $clog2(W + 1);

    logic [W-1:0]  win;
    logic [W-1:0]  win_nxt;
    logic [FW-1:0] fill;
    logic          half_hit;
    logic          full_hit;

    // Candidate window including the bit on the input this cycle.
    always_comb begin
        win_nxt  = {din, win[W-1:1]};
        half_hit = (win_nxt[W-1:HALF] == pattern[HALF-1:0]) && (fill >= FW'(HALF - 1));
        full_hit = (win_nxt == pattern) && (fill >= FW'(W - 1));
        match    = shift && (wide ? full_hit : half_hit);
    end

    // Window and fill-count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            win  <= '0;
            fill <= '0;
        end else if (shift) begin
            win  <= win_nxt;
            if (fill != FW'(W))
                fill <= fill + FW'(1);
        end
    end
endmodule

// File: rtl/char_framer.sv
// Character framer: gathers LSB-first bits into characters of CW-3+len_code
// bits and emits each right-justified with a one-cycle valid pulse.
// Assumes CW >= 4. Held empty while enable is low.
module char_framer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          shift,
    input  logic          din,
    input  logic [1:0]    len_code,
    output logic          out_valid,
    output logic [CW-1:0] out_data
);
    localparam int CNTW = $clog2(CW + 1);

    logic [CW-1:0]   sh;
    logic [CW-1:0]   sh_nxt;
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] need;
    logic [CNTW-1:0] gap;
    logic            last;

    // Length decode and end-of-character detection.
    always_comb begin
        sh_nxt = {din, sh[CW-1:1]};
        need   = CNTW'(CW - 3) + CNTW'(len_code);
        gap    = CNTW'(CW) - need;
        last   = enable && shift && (cnt == need - CNTW'(1));
    end

    // Assembly register, bit counter and output character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            cnt       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (!enable) begin
                sh  <= '0;
                cnt <= '0;
            end else if (last) begin
                out_valid <= 1'b1;
                out_data  <= sh_nxt >> gap;
                sh        <= '0;
                cnt       <= '0;
            end else if (shift) begin
                sh  <= sh_nxt;
                cnt <= cnt + CNTW'(1);
            end
        end
    end
endmodule

// File: rtl/crc_accum.sv
// Bit-serial 16-bit CRC: preset to a polynomial-specific seed, then one
// step per data bit, MSB-feedback form. Appending the remainder MSB first
// drives it back to zero. Preset wins over advance.
module crc_accum
    import sync_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic             sel,
    input  logic             advance,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] poly;
    logic             fb;

    // Polynomial selection and feedback bit.
    always_comb begin
        poly = sel ? POLY_CCITT : POLY_CRC16;
        fb   = crc[CRC_W-1] ^ din;
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc <= '0;
        else if (preset)
            crc <= sel ? SEED_CCITT : SEED_CRC16;
        else if (advance)
            crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
endmodule

// File: rtl/sync_hunt_rx.sv
// Top: hunt control for a character-oriented synchronous receiver.
// While hunting, bits feed the pattern window (or ext_sync is watched in
// external mode). On a hit the block leaves the hunt, presets the CRC and
// frames later bits into characters. hunt_cmd has priority over a hit.
module sync_hunt_rx
    import sync_rx_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_bit,
    input  logic [1:0]        mode,
    input  logic [CHAR_W-1:0] sync_lo,
    input  logic [CHAR_W-1:0] sync_hi,
    input  logic [1:0]        len_code,
    input  logic              crc_sel,
    input  logic              crc_en,
    input  logic              hunt_cmd,
    input  logic              ext_sync,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data,
    output logic              sync_found,
    output logic              crc_zero
);
    localparam int WIN_W = 2 * CHAR_W;

    logic             is_ext;
    logic             is_wide;
    logic             win_shift;
    logic             win_clear;
    logic             pat_hit;
    logic             ext_hit;
    logic             found_evt;
    logic             framing;
    logic [CRC_W-1:0] crc;

    // Mode decode and hunt-exit conditions.
    always_comb begin
        is_ext    = (hunt_mode_e'(mode) == MODE_EXT);
        is_wide   = (hunt_mode_e'(mode) == MODE_DOUBLE);
        win_shift = rx_valid && !sync_found && !is_ext && !hunt_cmd;
        win_clear = hunt_cmd || sync_found;
        ext_hit   = !sync_found && is_ext && ext_sync;
        found_evt = (pat_hit || ext_hit) && !hunt_cmd;
        framing   = sync_found && !hunt_cmd;
        crc_zero  = sync_found && (crc == '0);
    end

    // Hunt state: set on a hit, cleared by reset or a hunt command.
    always_ff @(posedge clk) begin
        if (!rst_n || hunt_cmd)
            sync_found <= 1'b0;
        else if (found_evt)
            sync_found <= 1'b1;
    end

    sync_window #(.W(WIN_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (win_clear),
        .shift   (win_shift),
        .din     (rx_bit),
        .wide    (is_wide),
        .pattern ({sync_hi, sync_lo}),
        .match   (pat_hit)
    );

    char_framer #(.CW(CHAR_W)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (framing),
        .shift     (rx_valid),
        .din       (rx_bit),
        .len_code  (len_code),
        .out_valid (char_valid),
        .out_data  (char_data)
    );

    crc_accum u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (found_evt),
        .sel     (crc_sel),
        .advance (framing && crc_en && rx_valid),
        .din     (rx_bit),
        .crc     (crc)
    );
endmodule

// File: rtl/sync_hunt_rx_chk.sv
// Checker: temporal properties of the sync-hunt receiver, on its ports.
module sync_hunt_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [1:0] mode,
    input logic       crc_en,
    input logic       hunt_cmd,
    input logic       ext_sync,
    input logic       char_valid,
    input logic       sync_found,
    input logic       crc_zero
);
    assert_char_when_synced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> sync_found);

    assert_hunt_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> (!sync_found && !char_valid));

    assert_no_char_in_hunt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_found |=> !char_valid);

    assert_lock_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_found) && $past(mode) != 2'd2) |-> $past(rx_valid));

    assert_ext_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_found) && $past(mode) == 2'd2) |-> $past(ext_sync));

    assert_crc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_found && !crc_en && !hunt_cmd) |=> $stable(crc_zero));
endmodule

bind sync_hunt_rx sync_hunt_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .mode       (mode),
    .crc_en     (crc_en),
    .hunt_cmd   (hunt_cmd),
    .ext_sync   (ext_sync),
    .char_valid (char_valid),
    .sync_found (sync_found),
    .crc_zero   (crc_zero)
);

// File: tb/sim_sync_hunt_rx.sv
// Directed bench for sync_hunt_rx: one task per scenario, each self-checking.
module sim_sync_hunt_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic       rx_bit = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [7:0] sync_lo = 8'h16;
    logic [7:0] sync_hi = 8'h00;
    logic [1:0] len_code = 2'd3;
    logic       crc_sel = 1'b0;
    logic       crc_en = 1'b0;
    logic       hunt_cmd = 1'b0;
    logic       ext_sync = 1'b0;
    logic       char_valid;
    logic [7:0] char_data;
    logic       sync_found;
    logic       crc_zero;

    int n_cmp = 0;
    int n_bad = 0;
    int n_chars = 0;
    logic [15:0] model;

    always #2 clk = ~clk;

    sync_hunt_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .mode(mode), .sync_lo(sync_lo), .sync_hi(sync_hi), .len_code(len_code),
        .crc_sel(crc_sel), .crc_en(crc_en), .hunt_cmd(hunt_cmd), .ext_sync(ext_sync),
        .char_valid(char_valid), .char_data(char_data),
        .sync_found(sync_found), .crc_zero(crc_zero)
    );

    // Count character pulses away from the active edge.
    always @(negedge clk) if (rst_n && char_valid) n_chars++;

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); rx_valid = 1'b1; rx_bit = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic pulse_hunt();
        @(negedge clk); hunt_cmd = 1'b1;
        @(negedge clk); hunt_cmd = 1'b0;
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b, input logic sel);
        logic fb;
        fb = c[15] ^ b;
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ (sel ? 16'h1021 : 16'h8005);
        return c;
    endfunction

    task automatic t_reset();
        check(!sync_found, "R1 sync_found", 16'(sync_found), 16'h0);
        check(!char_valid, "R1 char_valid", 16'(char_valid), 16'h0);
        check(!crc_zero, "R1 crc_zero", 16'(crc_zero), 16'h0);
    endtask

    task automatic t_single_sync();
        mode = 2'd0; sync_lo = 8'h16; len_code = 2'd3;
        send_bits(16'b101, 3);              // R4: offset junk
        send_bits(16'h16, 7);
        check(!sync_found, "R2 no early lock", 16'(sync_found), 16'h0);
        send_bit(1'b0);
        check(sync_found, "R2 lock on last bit", 16'(sync_found), 16'h1);
        check(n_chars == 0, "R10 no sync chars", 16'(n_chars), 16'h0);
        send_bits(16'hA5, 7);
        check(!char_valid, "R6 no early char", 16'(char_valid), 16'h0);
        send_bit(1'b1);
        check(char_valid && char_data == 8'hA5, "R6 len8 char", {8'h0, char_data}, 16'h00A5);
    endtask

    task automatic t_lengths();
        len_code = 2'd0; send_bits(16'h13, 5);
        check(char_valid && char_data == 8'h13, "R6 len5", {8'h0, char_data}, 16'h0013);
        len_code = 2'd1; send_bits(16'h2A, 6);
        check(char_valid && char_data == 8'h2A, "R6 len6", {8'h0, char_data}, 16'h002A);
        len_code = 2'd2; send_bits(16'h55, 7);
        check(char_valid && char_data == 8'h55, "R6 len7", {8'h0, char_data}, 16'h0055);
        len_code = 2'd3;
    endtask

    task automatic t_hunt_restart();
        pulse_hunt();
        check(!sync_found, "R7 cleared", 16'(sync_found), 16'h0);
        send_bits(16'h6, 4);                 // low half of 0x16
        pulse_hunt();
        send_bits(16'h1, 4);                 // high half of 0x16
        check(!sync_found, "R7 stale bits ignored", 16'(sync_found), 16'h0);
        send_bits(16'h16, 8);
        check(sync_found, "R7 relock", 16'(sync_found), 16'h1);
    endtask

    task automatic t_double_sync();
        pulse_hunt();
        mode = 2'd1; sync_lo = 8'h96; sync_hi = 8'h69;
        send_bits(16'h96, 8);
        check(!sync_found, "R3 low byte alone", 16'(sync_found), 16'h0);
        send_bits(16'h69, 8);
        check(sync_found, "R3 full pattern", 16'(sync_found), 16'h1);
    endtask

    task automatic t_ext();
        pulse_hunt();
        mode = 2'd2; sync_lo = 8'h16;
        send_bits(16'h16, 8);
        check(!sync_found, "R5 pattern ignored", 16'(sync_found), 16'h0);
        @(negedge clk); ext_sync = 1'b1;
        @(negedge clk); ext_sync = 1'b0;
        check(sync_found, "R5 ext lock", 16'(sync_found), 16'h1);
        send_bits(16'h3C, 8);
        check(char_valid && char_data == 8'h3C, "R5 ext char", {8'h0, char_data}, 16'h003C);
    endtask

    task automatic t_crc(input logic sel);
        logic [15:0] c;
        pulse_hunt();
        mode = 2'd0; sync_lo = 8'h16; crc_sel = sel; crc_en = 1'b1;
        send_bits(16'h16, 8);
        c = sel ? 16'hFFFF : 16'h0000;
        for (int i = 0; i < 16; i++) c = crc_step(c, 1'(16'h3412 >> i), sel);
        send_bits(16'h3412, 16);
        check(crc_zero == (c == 16'h0), "R8 after data", 16'(crc_zero), 16'(c == 16'h0));
        for (int i = 15; i >= 0; i--) send_bit(c[i]);
        check(crc_zero, "R8 zero remainder", 16'(crc_zero), 16'h1);
        crc_en = 1'b0;
        send_bits(16'hFF, 8);
        check(crc_zero, "R9 disabled hold", 16'(crc_zero), 16'h1);
        crc_en = 1'b1;
        c = 16'h0;
        for (int i = 0; i < 8; i++) c = crc_step(c, 1'(16'h01 >> i), sel);
        send_bits(16'h01, 8);
        check(crc_zero == (c == 16'h0), "R8 corrupted", 16'(crc_zero), 16'(c == 16'h0));
        crc_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_sync();
        t_lengths();
        t_hunt_restart();
        t_double_sync();
        t_ext();
        t_crc(1'b0);
        t_crc(1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule